// File: doc/BRIEF.md
# Indirect Byte Register Bridge

This block lets a host with a 32-bit memory-mapped register port reach an 8-bit internal register space that runs slower than the host. The host never addresses the internal bytes directly. It writes a control word that names a target byte address, a direction, a size and per-lane byte enables, then moves the data through two 32-bit data windows. A busy bit in the control word tells the host when a transfer is still in flight.

A read starts as soon as the control word is written with the read direction. When busy drops, the lower data window (and the upper window for a wide transfer) holds the fetched bytes. A write is armed by a control word with the write direction and starts when the host writes the lower data window. The slow side is modelled as a clock enable, `slow_tick_i`, and a transfer takes a fixed number of those ticks. The internal register space itself is modelled as a plain byte array that is cleared at reset.

Two interrupt sources are kept in a flag register with a matching enable register. The interface source fires when a transfer completes. The subsystem source follows an input line. The single interrupt output is raised whenever an enabled flag is set.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the control, both data windows, interrupt enable and interrupt flag registers read 0, irq_o is 0, every internal byte is 0, and offset 0x00 reads the parameter ID_VALUE.
- R2: The control word at offset 0x04 reads back as: bit 31 busy (writes to it have no effect), bit 25 size (1 = wide), bit 24 direction (1 = read), bits 23:20 upper-lane enables, bits 19:16 lower-lane enables (bit 16 = least significant byte), bits 7:0 target address; all other bits read 0.
- R3: A control write with direction 1 starts a read. Busy reads 1 from the next cycle. On completion, byte lane k of the lower window (offset 0x08) holds internal byte (addr+k) mod 256 when lower enable k is set, and 0 otherwise.
- R4: For a wide read (size 1), byte lane k of the upper window (offset 0x0C) holds byte (addr+4+k) mod 256 when upper enable k is set, and 0 otherwise. For a narrow read the upper window is left unchanged.
- R5: A control write with direction 0 arms a write, and the next lower-window write starts it. On completion, lower lane k goes to byte (addr+k) mod 256 when its enable is set. For size 1, upper lane k also goes to byte (addr+4+k) mod 256 when its enable is set. Bytes with a cleared enable are not changed.
- R6: A lower-window write with no write armed only stores the data and does not set busy.
- R7: While busy is 1, writes to the control word and to both data windows are ignored, and the transfer completes with its original command and data.
- R8: The interrupt flag register at 0x14 has bit 0 for the interface source and bit 1 for the subsystem source. Bit 0 sets on transfer completion and bit 1 sets while sub_irq_i is 1. Writing a 1 clears a bit, and a set in the same cycle wins over the clear. The enable register at 0x10 uses the same bit positions.
- R9: irq_o is 1 exactly when some flag bit and its enable bit are both 1.
- R10: Busy lasts exactly BUSY_TICKS cycles with slow_tick_i high, counting from the cycle after the start. Cycles without a tick do not advance the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle enable marking a slow-domain clock edge |
| host_req_i | input | 1 | Register access strobe |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | HOST_AW | Byte offset of the register |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| sub_irq_i | input | 1 | Subsystem interrupt request line |
| irq_o | output | 1 | Host interrupt |

## Verification
The hardest case to reach from the ports is a host access that lands while a transfer is in flight, combined with a slow tick that stalls. The write has to arrive after busy has risen but before the final tick. The stimulus therefore starts a read, holds `slow_tick_i` low for a stretch, and issues control and data writes inside that window. It then checks that the fetched bytes match the original command. A separate wide write at address 0xFE makes the upper lanes wrap around the byte space, and a later wide read fetches those bytes back.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam logic [7:0] OFF_ID   = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h04;
  localparam logic [7:0] OFF_LO   = 8'h08;
  localparam logic [7:0] OFF_HI   = 8'h0C;
  localparam logic [7:0] OFF_IEN  = 8'h10;
  localparam logic [7:0] OFF_IFLG = 8'h14;

  localparam int unsigned LANES = 4;

  typedef struct packed {
    logic             wide;
    logic             rd;
    logic [LANES-1:0] en_hi;
    logic [LANES-1:0] en_lo;
    logic [7:0]       addr;
  } cmd_t;

  function automatic cmd_t cmd_from_word(input logic [31:0] w);
    cmd_t c;
    c.wide  = w[25];
    c.rd    = w[24];
    c.en_hi = w[23:20];
    c.en_lo = w[19:16];
    c.addr  = w[7:0];
    return c;
  endfunction

  function automatic logic [31:0] cmd_to_word(input cmd_t c, input logic busy);
    return {busy, 5'b0, c.wide, c.rd, c.en_hi, c.en_lo, 8'h00, c.addr};
  endfunction
endpackage

// File: rtl/ibr_xfer_seq.sv
module ibr_xfer_seq #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done_o = busy_q && tick_i && (cnt_q == CW'(TICKS - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (tick_i) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  p_done_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  p_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> (busy_q && $stable(cnt_q)));
endmodule

// File: rtl/ibr_byte_space.sv
module ibr_byte_space #(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      base_i,
  input  logic               wr_i,
  input  logic [LANES-1:0]   wmask_i,
  input  logic [LANES*8-1:0] wdata_i,
  output logic [LANES*8-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (wr_i) begin
      for (int k = 0; k < LANES; k++)
        if (wmask_i[k]) mem_q[AW'(base_i + AW'(k))] <= wdata_i[k*8 +: 8];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rdata_o[k*8 +: 8] = mem_q[AW'(base_i + AW'(k))];
  end
endmodule

// File: rtl/ibr_irq_regs.sv
module ibr_irq_regs #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         flag_we_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      flag_q <= (flag_q & ~(flag_we_i ? wdata_i : '0)) | set_i;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = |(en_q & flag_q);

  for (genvar b = 0; b < N; b++) begin : g_chk
    p_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> flag_q[b]);
    p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_we_i && wdata_i[b] && !set_i[b]) |=> !flag_q[b]);
  end
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned HOST_AW    = 5,
  parameter int unsigned BUSY_TICKS = 4,
  parameter logic [31:0] ID_VALUE   = 32'h1B2D_0001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               slow_tick_i,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [31:0]        host_wdata_i,
  output logic [31:0]        host_rdata_o,
  input  logic               sub_irq_i,
  output logic               irq_o
);
  localparam int unsigned NIRQ = 2;

  logic host_wr;
  logic sel_ctrl, sel_lo, sel_hi, sel_ien, sel_iflg;
  logic busy, done;
  logic start_rd, start_wr, wr_ctrl, wr_lo, wr_hi;
  logic armed_q;
  cmd_t cmd_q;
  logic [31:0] lo_q, hi_q, lo_fetch, hi_fetch;
  logic [2*LANES*8-1:0] space_rd;
  logic [NIRQ-1:0] ien, iflg;

  assign host_wr  = host_req_i && host_we_i;
  assign sel_ctrl = host_addr_i == HOST_AW'(OFF_CTRL);
  assign sel_lo   = host_addr_i == HOST_AW'(OFF_LO);
  assign sel_hi   = host_addr_i == HOST_AW'(OFF_HI);
  assign sel_ien  = host_addr_i == HOST_AW'(OFF_IEN);
  assign sel_iflg = host_addr_i == HOST_AW'(OFF_IFLG);

  // command and data writes are locked out for the whole transfer
  assign wr_ctrl  = host_wr && sel_ctrl && !busy;
  assign wr_lo    = host_wr && sel_lo && !busy;
  assign wr_hi    = host_wr && sel_hi && !busy;
  assign start_rd = wr_ctrl && host_wdata_i[24];
  assign start_wr = wr_lo && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_ctrl) begin
      cmd_q   <= cmd_from_word(host_wdata_i);
      armed_q <= !host_wdata_i[24];
    end else if (start_wr) begin
      armed_q <= 1'b0;
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lo_fetch[k*8 +: 8] = cmd_q.en_lo[k] ? space_rd[k*8 +: 8] : 8'h00;
      hi_fetch[k*8 +: 8] = cmd_q.en_hi[k] ? space_rd[(LANES+k)*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (done && cmd_q.rd) begin
      lo_q <= lo_fetch;
      if (cmd_q.wide) hi_q <= hi_fetch;
    end else begin
      if (wr_lo) lo_q <= host_wdata_i;
      if (wr_hi) hi_q <= host_wdata_i;
    end
  end

  ibr_xfer_seq #(.TICKS(BUSY_TICKS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_rd || start_wr),
    .tick_i  (slow_tick_i),
    .busy_o  (busy),
    .done_o  (done)
  );

  ibr_byte_space #(.AW(8), .LANES(2*LANES)) u_space (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .base_i  (cmd_q.addr),
    .wr_i    (done && !cmd_q.rd),
    .wmask_i ({cmd_q.wide ? cmd_q.en_hi : {LANES{1'b0}}, cmd_q.en_lo}),
    .wdata_i ({hi_q, lo_q}),
    .rdata_o (space_rd)
  );

  ibr_irq_regs #(.N(NIRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_we_i   (host_wr && sel_ien),
    .flag_we_i (host_wr && sel_iflg),
    .wdata_i   (host_wdata_i[NIRQ-1:0]),
    .set_i     ({sub_irq_i, done}),
    .en_o      (ien),
    .flag_o    (iflg),
    .irq_o     (irq_o)
  );

  always_comb begin
    host_rdata_o = '0;
    unique case (1'b1)
      sel_ctrl: host_rdata_o = cmd_to_word(cmd_q, busy);
      sel_lo:   host_rdata_o = lo_q;
      sel_hi:   host_rdata_o = hi_q;
      sel_ien:  host_rdata_o = 32'(ien);
      sel_iflg: host_rdata_o = 32'(iflg);
      default:  host_rdata_o = (host_addr_i == HOST_AW'(OFF_ID)) ? ID_VALUE : '0;
    endcase
  end

  p_cmd_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && host_wr && sel_ctrl) |=> $stable(cmd_q));
  p_lo_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> $stable(lo_q));
  p_no_spurious_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_rd && !start_wr) |=> !busy);
  p_narrow_hi_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !cmd_q.wide) |=> $stable(hi_q));
endmodule

// File: tb/ibr_bridge_bench.sv
`timescale 1ns/1ps
module ibr_bridge_bench;
  localparam int T = 4;
  localparam logic [31:0] ID = 32'h1B2D_0001;

  logic clk = 0, rst_n = 0;
  logic tick = 0, req = 0, we = 0, sub = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit finished = 0;
  string cur_tag = "R1";
  bit tick_auto = 1;
  int cyc = 0;

  always #4 clk = ~clk;

  ibr_bridge #(.HOST_AW(5), .BUSY_TICKS(T), .ID_VALUE(ID)) u_ibr_bridge (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(tick), .host_req_i(req),
    .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .sub_irq_i(sub), .irq_o(irq));

  // behavioural reference
  logic [7:0] m_mem [256];
  bit m_busy, m_armed, m_wide, m_rd;
  int m_cnt;
  logic [3:0] m_bu, m_bl;
  logic [7:0] m_addr;
  logic [31:0] m_lo, m_hi;
  logic [1:0] m_en, m_flag;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return ID;
      5'h04: return {m_busy, 5'b0, m_wide, m_rd, m_bu, m_bl, 8'h00, m_addr};
      5'h08: return m_lo;
      5'h0C: return m_hi;
      5'h10: return {30'b0, m_en};
      5'h14: return {30'b0, m_flag};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
      m_busy = 0; m_armed = 0; m_wide = 0; m_rd = 0; m_cnt = 0;
      m_bu = 0; m_bl = 0; m_addr = 0; m_lo = 0; m_hi = 0; m_en = 0; m_flag = 0;
    end else begin
      bit fin, wr;
      logic [1:0] clr;
      fin = m_busy && tick && (m_cnt == T - 1);
      wr  = req && we;
      clr = (wr && addr == 5'h14) ? wdata[1:0] : 2'b00;
      if (wr && addr == 5'h10) m_en = wdata[1:0];
      m_flag = (m_flag & ~clr) | {sub, fin};
      if (fin) begin
        for (int k = 0; k < 4; k++) begin
          if (m_rd) begin
            m_lo[k*8 +: 8] = m_bl[k] ? m_mem[8'(m_addr + k)] : 8'h00;
            if (m_wide) m_hi[k*8 +: 8] = m_bu[k] ? m_mem[8'(m_addr + 4 + k)] : 8'h00;
          end
        end
        if (!m_rd)
          for (int k = 0; k < 4; k++) begin
            if (m_bl[k]) m_mem[8'(m_addr + k)] = m_lo[k*8 +: 8];
            if (m_wide && m_bu[k]) m_mem[8'(m_addr + 4 + k)] = m_hi[k*8 +: 8];
          end
        m_busy = 0;
      end else if (m_busy && tick) begin
        m_cnt++;
      end else if (!m_busy && wr) begin
        if (addr == 5'h04) begin
          {m_wide, m_rd, m_bu, m_bl} = wdata[25:16];
          m_addr = wdata[7:0];
          m_armed = !wdata[24];
          if (wdata[24]) begin m_busy = 1; m_cnt = 0; end
        end else if (addr == 5'h08) begin
          m_lo = wdata;
          if (m_armed) begin m_armed = 0; m_busy = 1; m_cnt = 0; end
        end else if (addr == 5'h0C) begin
          m_hi = wdata;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n && !finished) begin
    checks++;
    if (irq !== ((m_flag & m_en) != 0)) begin
      errors++;
      $display("FAIL R9 irq_o actual=%0b expected=%0b", irq, (m_flag & m_en) != 0);
    end
    if (req && !we) begin
      logic [31:0] e;
      e = m_read(addr);
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s read @%02h actual=%08h expected=%08h", cur_tag, addr, rdata, e);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    cyc++;
    if (tick_auto) tick = (cyc % 3 == 0);
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; req = 0; we = 0; end
  endtask
  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1; req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); #1; req = 0; we = 0;
  endtask
  task automatic rd_reg(input logic [4:0] a, input string tag);
    @(negedge clk); #1; req = 1; we = 0; addr = a; cur_tag = tag;
    @(negedge clk); #1; req = 0;
  endtask
  task automatic wait_idle(input string tag);
    int n = 0;
    do begin rd_reg(5'h04, tag); n++; end while (m_busy && n < 200);
  endtask
  function automatic logic [31:0] cw(input bit w, input bit r, input logic [3:0] bu,
                                     input logic [3:0] bl, input logic [7:0] a);
    return {6'b0, w, r, bu, bl, 8'h00, a};
  endfunction

  initial begin
    #100000;
    if (!finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    rd_reg(5'h00, "R1"); rd_reg(5'h04, "R1"); rd_reg(5'h08, "R1");
    rd_reg(5'h0C, "R1"); rd_reg(5'h10, "R1"); rd_reg(5'h14, "R1");
    // R5 narrow write, then R3 read back
    wr_reg(5'h10, 32'h1);
    wr_reg(5'h04, cw(0, 0, 4'h0, 4'hF, 8'h10));
    wr_reg(5'h08, 32'h4433_2211);
    rd_reg(5'h04, "R10");
    wait_idle("R10");
    rd_reg(5'h14, "R8");
    wr_reg(5'h14, 32'h1);
    rd_reg(5'h14, "R8");
    wr_reg(5'h04, cw(0, 1, 4'h0, 4'hF, 8'h10));
    wait_idle("R3"); rd_reg(5'h08, "R3");
    wr_reg(5'h04, cw(0, 1, 4'h0, 4'h5, 8'h10));
    wait_idle("R3"); rd_reg(5'h08, "R3");
    // R5 partial write keeps disabled bytes
    wr_reg(5'h04, cw(0, 0, 4'h0, 4'h2, 8'h10));
    wr_reg(5'h08, 32'hAAAA_EEAA);
    wait_idle("R5");
    wr_reg(5'h04, cw(0, 1, 4'h0, 4'hF, 8'h10));
    wait_idle("R5"); rd_reg(5'h08, "R5");
    // R4/R5 wide write wrapping the byte space
    wr_reg(5'h0C, 32'hDDCC_BBAA);
    wr_reg(5'h04, cw(1, 0, 4'hC, 4'h3, 8'hFE));
    wr_reg(5'h08, 32'h5566_7788);
    wait_idle("R5");
    wr_reg(5'h0C, 32'h1234_5678);
    wr_reg(5'h04, cw(0, 1, 4'hF, 4'hF, 8'hFE));
    wait_idle("R4"); rd_reg(5'h08, "R4"); rd_reg(5'h0C, "R4");
    wr_reg(5'h04, cw(1, 1, 4'hF, 4'hF, 8'hFE));
    wait_idle("R4"); rd_reg(5'h08, "R4"); rd_reg(5'h0C, "R4");
    // R6 data write without an armed command
    wr_reg(5'h08, 32'hCAFE_F00D);
    rd_reg(5'h04, "R6"); rd_reg(5'h08, "R6");
    // R7 + R10: writes during a stalled transfer
    tick_auto = 0; tick = 0;
    wr_reg(5'h04, cw(0, 1, 4'h0, 4'hF, 8'h00));
    wr_reg(5'h04, cw(1, 0, 4'hF, 4'hF, 8'h40));
    wr_reg(5'h08, 32'hFFFF_FFFF);
    wr_reg(5'h0C, 32'hEEEE_EEEE);
    idle(8);
    rd_reg(5'h04, "R7"); rd_reg(5'h0C, "R7");
    tick_auto = 1;
    wait_idle("R10"); rd_reg(5'h08, "R7"); rd_reg(5'h0C, "R7");
    // R2 control readback with bit 31 and spare bits written
    wr_reg(5'h04, 32'hFCFF_FF3C & ~32'h0100_0000);
    rd_reg(5'h04, "R2");
    // R8/R9 subsystem source, set wins over clear
    wr_reg(5'h10, 32'h2);
    @(negedge clk); #1; sub = 1;
    idle(2); rd_reg(5'h14, "R8");
    @(negedge clk); #1; req = 1; we = 1; addr = 5'h14; wdata = 32'h3;
    @(negedge clk); #1; req = 0; we = 0;
    rd_reg(5'h14, "R8");
    sub = 0;
    wr_reg(5'h14, 32'h3);
    rd_reg(5'h14, "R8");
    wr_reg(5'h10, 32'h0);
    idle(4);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule